// File: doc/BRIEF.md
# Bank Auto-Precharge Timing Tracker

This block follows the state of every bank of a DDR SDRAM from the controller side. It judges whether each command is legal, and it works out when a bank's self-timed precharge runs after a read with auto precharge. It watches a command bus carrying a bank address. Burst length, minimum row-active time (tRAS) and row-precharge time (tRP) are given as configuration inputs in clock cycles. Each bank has its own row-active, trigger-delay and precharge counters.

After a read with auto precharge, the internal precharge of that bank begins in the later of two cycles. One is half a burst length after the read. The other is the cycle in which tRAS since the bank's activate is met. The bank then stays locked for tRP cycles. The block shows whether the command now on the bus is legal. It also gives a legality vector for every candidate command on every bank, and the state of each bank. An illegal command sets a sticky error that keeps the bank of the first offence. An illegal command is otherwise ignored.

Top module: `ap_bank_tracker`

## Requirements
- R1: Command codes are nop=0, activate=1, read=2, read with auto precharge=3, precharge=4, and any other code is illegal. Bank states are idle=0, active=1, precharge pending=2, precharging=3, two bits per bank in `state_o`. Per bank, `can_o` bit 0 is activate, bit 1 read, bit 2 read with auto precharge, bit 3 precharge. After reset every bank is idle, every counter is cleared and `err_o` is low.
- R2: A read with auto precharge issued in cycle r, with tRAS already met at r+BL/2, starts the internal precharge in cycle r+BL/2. The bank reads as pending up to and including that cycle, and as precharging from the next one.
- R3: When tRAS (counted from the activate in cycle a) is not yet met at r+BL/2, the start is postponed to cycle a+tRAS.
- R4: If the precharge starts in cycle s, activate is illegal before cycle s+tRP and legal from cycle s+tRP. Once activated in that cycle the bank is active. Otherwise it is idle from s+tRP+1. A tRP of 0 acts as 1.
- R5: While a bank is pending or precharging (before its tRP ends), every non-nop command to it is illegal and its four `can_o` bits are 0.
- R6: Commands to other banks keep their normal legality in every cycle of one bank's auto precharge. They are accepted and change only their own bank.
- R7: An illegal command raises `err_o` from the next cycle until reset. `err_bank_o` holds the bank of the first illegal command. The command changes neither the state nor the timing of any bank.
- R8: Activate is legal only on an idle bank. Read and read with auto precharge are legal only on an active bank. Precharge is legal on an idle bank, where it has no effect, and on an active bank once tRAS is met. In the active case it starts the precharge in the cycle it is issued.
- R9: `cmd_legal_o` gives the legality of the command and bank now on the bus. A nop is always legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code (R1) |
| bank_i | input | 2 | Bank the command addresses |
| burst_len_i | input | 6 | Burst length in beats |
| tras_i | input | 6 | Minimum row-active time in cycles |
| trp_i | input | 6 | Row-precharge time in cycles |
| cmd_legal_o | output | 1 | Current bus command is legal |
| can_o | output | 16 | Per-bank candidate-command legality, 4 bits per bank |
| state_o | output | 8 | Per-bank state, 2 bits per bank |
| err_o | output | 1 | Sticky illegal-command flag |
| err_bank_o | output | 2 | Bank of the first illegal command |

## Verification
The bench builds the block with its defaults: four banks and 6-bit counters. It then reloads the configuration inputs after each reset, giving burst lengths 4 and 8 and tRAS from 0 to 8. This places the trigger in turn on the burst-length side and on the tRAS side, so both branches of the start rule are exercised. Short tRP values of 1 to 3 keep the re-activate cycle within a few clocks of the start, so the cycle just before the release and the release cycle can both be checked. A second bank is driven during a first bank's pending window to show that the banks are independent.

// File: rtl/sdr_ap_pkg.sv
package sdr_ap_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_RDA = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_PEND = 2'd2,
    ST_PCH  = 2'd3
  } bank_st_e;

  localparam int unsigned CAN_ACT = 0;
  localparam int unsigned CAN_RD  = 1;
  localparam int unsigned CAN_RDA = 2;
  localparam int unsigned CAN_PRE = 3;
  localparam int unsigned CAN_W   = 4;
endpackage

// File: rtl/ap_bank_fsm.sv
module ap_bank_fsm
  import sdr_ap_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  cmd_e             cmd_i,
  input  logic [CNT_W-1:0] dly_ld_i,
  input  logic [CNT_W-1:0] tras_ld_i,
  input  logic [CNT_W-1:0] trp_ld_i,
  output logic [CAN_W-1:0] can_o,
  output bank_st_e         state_o
);
  bank_st_e         state_q;
  logic [CNT_W-1:0] tras_q, dly_q, trp_q;
  logic             tras_ok, pch_done, start_now, my_legal, acc;

  assign tras_ok   = (tras_q == '0);
  assign pch_done  = (state_q == ST_PCH) && (trp_q == '0);
  assign start_now = (state_q == ST_PEND) && (dly_q == '0) && tras_ok;

  always_comb begin
    can_o          = '0;
    can_o[CAN_ACT] = (state_q == ST_IDLE) || pch_done;
    can_o[CAN_RD]  = (state_q == ST_ACT);
    can_o[CAN_RDA] = (state_q == ST_ACT);
    can_o[CAN_PRE] = (state_q == ST_IDLE) || pch_done || ((state_q == ST_ACT) && tras_ok);
  end

  always_comb begin
    case (cmd_i)
      CMD_NOP: my_legal = 1'b1;
      CMD_ACT: my_legal = can_o[CAN_ACT];
      CMD_RD:  my_legal = can_o[CAN_RD];
      CMD_RDA: my_legal = can_o[CAN_RDA];
      CMD_PRE: my_legal = can_o[CAN_PRE];
      default: my_legal = 1'b0;
    endcase
  end

  assign acc = sel_i && my_legal && (cmd_i != CMD_NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tras_q  <= '0;
      dly_q   <= '0;
      trp_q   <= '0;
    end else begin
      if (acc && cmd_i == CMD_ACT)  tras_q <= tras_ld_i;
      else if (tras_q != '0)        tras_q <= tras_q - 1'b1;

      if (acc && cmd_i == CMD_RDA)  dly_q <= dly_ld_i;
      else if (dly_q != '0)         dly_q <= dly_q - 1'b1;

      case (state_q)
        ST_IDLE: if (acc && cmd_i == CMD_ACT) state_q <= ST_ACT;
        ST_ACT: begin
          if (acc && cmd_i == CMD_RDA) state_q <= ST_PEND;
          else if (acc && cmd_i == CMD_PRE) begin
            state_q <= ST_PCH;
            trp_q   <= trp_ld_i;
          end
        end
        ST_PEND: begin
          if (start_now) begin
            state_q <= ST_PCH;
            trp_q   <= trp_ld_i;
          end
        end
        default: begin
          if (trp_q != '0)                   trp_q   <= trp_q - 1'b1;
          else if (acc && cmd_i == CMD_ACT)  state_q <= ST_ACT;
          else                               state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign state_o = state_q;

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_PEND && state_q == ST_PCH) |-> ($past(tras_q) == '0 && $past(dly_q) == '0)); // R3
  AST_TRP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_PCH && $past(trp_q) != '0) |-> state_q == ST_PCH); // R4
  AST_PRE_AFTER_TRAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_ACT && state_q == ST_PCH) |-> $past(tras_q) == '0); // R8
  AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !my_legal) |=> $stable(state_q)); // R7
endmodule

// File: rtl/ap_err_log.sv
module ap_err_log #(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bad_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              err_o,
  output logic [BANK_W-1:0] err_bank_o
);
  logic              err_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      bank_q <= '0;
    end else if (bad_i && !err_q) begin
      err_q  <= 1'b1;
      bank_q <= bank_i;
    end
  end

  assign err_o      = err_q;
  assign err_bank_o = bank_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_q) |-> err_q); // R7
  AST_ERR_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_q) |-> $stable(bank_q)); // R7
endmodule

// File: rtl/ap_bank_tracker.sv
module ap_bank_tracker
  import sdr_ap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned CNT_W     = 6,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 cmd_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [CNT_W-1:0]           burst_len_i,
  input  logic [CNT_W-1:0]           tras_i,
  input  logic [CNT_W-1:0]           trp_i,
  output logic                       cmd_legal_o,
  output logic [NUM_BANKS*CAN_W-1:0] can_o,
  output logic [NUM_BANKS*2-1:0]     state_o,
  output logic                       err_o,
  output logic [BANK_W-1:0]          err_bank_o
);
  cmd_e             cmd;
  logic [CNT_W-1:0] half_bl, dly_ld, tras_ld, trp_ld;
  logic [CAN_W-1:0] can_a [NUM_BANKS];

  assign cmd     = cmd_e'(cmd_i);
  assign half_bl = burst_len_i >> 1;
  assign dly_ld  = (half_bl == '0) ? '0 : half_bl - 1'b1;
  assign tras_ld = (tras_i == '0) ? '0 : tras_i - 1'b1;
  assign trp_ld  = (trp_i == '0) ? '0 : trp_i - 1'b1;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_st_e st;
    ap_bank_fsm #(.CNT_W(CNT_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (bank_i == BANK_W'(g)),
      .cmd_i     (cmd),
      .dly_ld_i  (dly_ld),
      .tras_ld_i (tras_ld),
      .trp_ld_i  (trp_ld),
      .can_o     (can_a[g]),
      .state_o   (st)
    );
    assign can_o[g*CAN_W +: CAN_W] = can_a[g];
    assign state_o[g*2 +: 2]       = st;
  end

  always_comb begin
    case (cmd)
      CMD_NOP: cmd_legal_o = 1'b1;
      CMD_ACT: cmd_legal_o = can_a[bank_i][CAN_ACT];
      CMD_RD:  cmd_legal_o = can_a[bank_i][CAN_RD];
      CMD_RDA: cmd_legal_o = can_a[bank_i][CAN_RDA];
      CMD_PRE: cmd_legal_o = can_a[bank_i][CAN_PRE];
      default: cmd_legal_o = 1'b0;
    endcase
  end

  ap_err_log #(.BANK_W(BANK_W)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bad_i      (!cmd_legal_o),
    .bank_i     (bank_i),
    .err_o      (err_o),
    .err_bank_o (err_bank_o)
  );
endmodule

// File: tb/ap_bank_tracker_tb.sv
module ap_bank_tracker_tb;
  localparam int NB = 4;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, RDA = 3'd3, PRE = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = '0;
  logic [5:0] bl = 6'd4, tras = 6'd2, trp = 6'd3;
  logic       legal, err;
  logic [15:0] can;
  logic [7:0]  st;
  logic [1:0]  err_bank;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ap_bank_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank),
    .burst_len_i(bl), .tras_i(tras), .trp_i(trp),
    .cmd_legal_o(legal), .can_o(can), .state_o(st),
    .err_o(err), .err_bank_o(err_bank)
  );

  function automatic int st_of(input int b); return int'(st[b*2 +: 2]); endfunction
  function automatic int can_of(input int b, input int k); return int'(can[b*4+k]); endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // one bus cycle: drive at negedge, settle, return for sampling before posedge
  task automatic cyc(input logic [2:0] c, input int b);
    @(negedge clk);
    cmd  = c;
    bank = 2'(b);
    #1;
  endtask

  task automatic do_reset(input int b_l, input int t_ras, input int t_rp);
    @(negedge clk);
    rst_n = 1'b0;
    cmd = NOP;
    bl = 6'(b_l); tras = 6'(t_ras); trp = 6'(t_rp);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(4, 2, 3);
    cyc(NOP, 0);
    chk("R1 state after reset", int'(st), 0);
    chk("R1 can after reset", int'(can), 16'h9999);
    chk("R1 err after reset", int'(err), 0);
    chk("R9 nop legal", int'(legal), 1);
  endtask

  task automatic t_bl_trigger();
    do_reset(4, 2, 3);
    cyc(ACT, 0); chk("R8 act on idle legal", int'(legal), 1);
    cyc(NOP, 0);
    chk("R8 bank active", st_of(0), 1);
    chk("R8 pre before tras", can_of(0, 3), 0);
    chk("R8 act on active illegal", can_of(0, 0), 0);
    cyc(RDA, 0);
    chk("R9 rda legal", int'(legal), 1);
    chk("R8 pre after tras", can_of(0, 3), 1);
    cyc(NOP, 0);
    chk("R5 pending can", int'(can[3:0]), 0);
    chk("R6 other bank act", can_of(1, 0), 1);
    cyc(NOP, 0); chk("R2 still pending at r+BL/2", st_of(0), 2);
    cyc(NOP, 0); chk("R2 precharging after start", st_of(0), 3);
    chk("R5 act during trp", can_of(0, 0), 0);
    cyc(NOP, 0); chk("R4 act before s+trp", can_of(0, 0), 0);
    cyc(NOP, 0); chk("R4 act at s+trp", can_of(0, 0), 1);
    cyc(NOP, 0); chk("R4 idle afterwards", st_of(0), 0);
  endtask

  task automatic t_tras_trigger();
    do_reset(4, 8, 2);
    cyc(ACT, 0);
    cyc(RDA, 0);
    cyc(NOP, 0);
    cyc(ACT, 2); chk("R6 act other bank legal", int'(legal), 1);
    cyc(NOP, 0);
    cyc(RD, 2);  chk("R6 read other bank legal", int'(legal), 1);
    cyc(NOP, 0); chk("R6 other bank active", st_of(2), 1);
    cyc(NOP, 0); chk("R3 pending past BL/2", st_of(0), 2);
    cyc(NOP, 0); chk("R3 pending at a+tras", st_of(0), 2);
    cyc(NOP, 0); chk("R3 precharging after a+tras", st_of(0), 3);
    chk("R4 act illegal before s+trp", can_of(0, 0), 0);
    cyc(ACT, 0); chk("R4 act legal at s+trp", int'(legal), 1);
    cyc(NOP, 0); chk("R4 reactivated", st_of(0), 1);
    chk("R6 no error", int'(err), 0);
  endtask

  task automatic t_illegal();
    do_reset(4, 2, 3);
    cyc(ACT, 0);
    cyc(NOP, 0);
    cyc(RDA, 0);
    cyc(RD, 0);  chk("R5 read while pending illegal", int'(legal), 0);
    cyc(ACT, 3);
    chk("R7 err raised", int'(err), 1);
    chk("R7 err bank", int'(err_bank), 0);
    cyc(RDA, 1); chk("R8 rda on idle illegal", int'(legal), 0);
    cyc(PRE, 2); chk("R8 pre on idle legal", int'(legal), 1);
    chk("R7 illegal rda left bank idle", st_of(1), 0);
    cyc(NOP, 0);
    chk("R8 pre on idle no effect", st_of(2), 0);
    chk("R7 schedule intact", can_of(0, 0), 1);
    chk("R7 first bank kept", int'(err_bank), 0);
    chk("R7 err sticky", int'(err), 1);
    cyc(3'd6, 1); chk("R1 undefined code illegal", int'(legal), 0);
  endtask

  task automatic t_bl8();
    do_reset(8, 0, 1);
    cyc(ACT, 1);
    cyc(RDA, 1);
    cyc(NOP, 0);
    cyc(NOP, 0);
    cyc(NOP, 0); chk("R2 bl8 act blocked", can_of(1, 0), 0);
    cyc(NOP, 0); chk("R2 bl8 pending at r+4", st_of(1), 2);
    cyc(NOP, 0);
    chk("R2 bl8 precharging", st_of(1), 3);
    chk("R4 trp1 act legal", can_of(1, 0), 1);
  endtask

  task automatic t_explicit_pre();
    do_reset(4, 3, 2);
    cyc(ACT, 3);
    cyc(NOP, 0); chk("R8 pre blocked by tras", can_of(3, 3), 0);
    cyc(NOP, 0);
    cyc(PRE, 3); chk("R8 pre legal at tras", int'(legal), 1);
    cyc(NOP, 0); chk("R8 pre starts precharge", st_of(3), 3);
    chk("R4 act blocked", can_of(3, 0), 0);
    cyc(NOP, 0); chk("R4 act legal after pre", can_of(3, 0), 1);
    chk("R9 no error", int'(err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    t_reset();
    t_bl_trigger();
    t_tras_trigger();
    t_illegal();
    t_bl8();
    t_explicit_pre();
    summary();
  end
endmodule